// File: doc/BRIEF.md
# Serial EEPROM Read Target

This block answers read transfers on a two-wire I2C bus in front of a 2048-byte storage array. It oversamples the bus clock (SCL) and data (SDA) lines with the system clock and finds start and stop conditions and SCL edges. It then takes part in three kinds of read. The first is a current-address read, which continues from an internal pointer. The second is a random read, where a dummy write loads the pointer and a repeated start opens the read. The third is a sequential read, where every byte the controller acknowledges makes the target send the following byte.

The 11-bit array address is split across the transfer. Its three upper bits travel in the device address byte and its eight lower bits travel in the word address byte. The target never drives SDA high. It only pulls the line low through an output-enable, for acknowledge bits and for zero data bits. A separate byte-load port fills the array directly, so the array can hold known contents before bus traffic starts.

Top module: `eeprom_read_target`

## Requirements
- R1: After reset, `sda_oe` is low and every array location that has never been loaded reads back as 0xFF.
- R2: A device address byte whose four leading bits (sent first) are 1010 is acknowledged by pulling SDA low during the ninth SCL pulse. Any other leading code gets no acknowledge, and the rest of that transfer up to the next start or stop is ignored and leaves the read pointer unchanged.
- R3: Random read: a device byte with R/W (its last bit) = 0 sets pointer bits 10..8 from its bits 3..1. The following acknowledged word address byte sets pointer bits 7..0. After a repeated start and a device byte with R/W = 1, the target returns the byte stored at that address.
- R4: Each data byte leaves the target most significant bit first. Each bit is held on SDA for the whole high phase of its SCL pulse.
- R5: Every time a data byte has been sent in full, the pointer advances by one. An acknowledge from the controller makes the target send the byte at the new pointer, and address 0x7FF is followed by 0x000.
- R6: A not-acknowledge (SDA high on the ninth pulse of a data byte) ends the read, and the target leaves SDA released.
- R7: A read that is not preceded by a dummy write starts at the pointer left by the previous transfer. The address bits in the device byte are not used for such a read.
- R8: A stop condition at any moment returns the target to idle with SDA released. A byte cut short by the stop changes neither the pointer nor the memory.
- R9: `sda_oe` changes value only while the synchronized SCL is low.
- R10: A pulse on `load_we` writes `load_data` to `load_addr`, and a later bus read of that address returns it.
- R11: After the word address byte of a write, any further byte sent before the next start or stop gets no acknowledge and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| load_we | input | 1 | Byte-load strobe for the array |
| load_addr | input | 11 | Array address for a byte load |
| load_data | input | 8 | Byte to store on a byte load |

## Verification
Each reaction of the target (acknowledge on, acknowledge off, next data bit) is timed from an SCL falling edge. It appears on `sda_oe` after the third rising clock edge that follows the fall reaching the pin: two synchronizer stages, the edge detector's compare, then the state registers. The bench holds every SCL phase for 20 clocks. It reads SDA 10 clocks into each high phase and checks that `sda_oe` is unchanged just before SCL falls again, so every sample falls well after the due cycle. Pointer effects are checked through the data returned by the next read, never through internal state.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

  // Width of one bus byte; the protocol fixes it.
  localparam int BYTE_W = 8;

  // Engine phases. Only the checker and the engine inspect this type.
  typedef enum logic [2:0] {
    ST_IDLE,      // released, waiting for a start
    ST_DEV,       // shifting in the device address byte
    ST_DEV_ACK,   // ninth pulse after an accepted device byte
    ST_WADDR,     // shifting in the word address byte
    ST_WADDR_ACK, // ninth pulse after the word address byte
    ST_TX,        // shifting a data byte out
    ST_TX_ACK     // sampling the controller's acknowledge
  } state_t;

  // True when the leading four bits of a received byte hold the given code.
  function automatic logic code_hit(input logic [BYTE_W-1:0] b, input logic [3:0] code);
    return b[BYTE_W-1 -: 4] == code;
  endfunction

  // The R/W flag sits in the last bit of the device byte; 1 means read.
  function automatic logic is_read(input logic [BYTE_W-1:0] b);
    return b[0];
  endfunction

endpackage

// File: rtl/eerd_line_sync.sv
module eerd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  // Lines idle high, so every stage resets to 1.
  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_pipe <= '1;
        sda_pipe <= '1;
      end else begin
        scl_pipe <= scl_in;
        sda_pipe <= sda_in;
      end
    end
  end else begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_pipe <= '1;
        sda_pipe <= '1;
      end else begin
        scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
        sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      end
    end
  end

  // One more register per line gives the previous level for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  // SDA may only move with SCL held high for a start or a stop.
  assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/eerd_store.sv
module eerd_store #(
  parameter int ADDR_W = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [eerd_pkg::BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [eerd_pkg::BYTE_W-1:0] rd_data
);
  import eerd_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [BYTE_W-1:0] ERASED = '1;

  logic [BYTE_W-1:0] cells [DEPTH];
  logic [DEPTH-1:0]  filled;

  // Payload cells carry no reset; one flag per cell records a load.
  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     filled <= '0;
    else if (wr_en) filled[wr_addr] <= 1'b1;
  end

  // An untouched cell presents the erased value.
  assign rd_data = filled[rd_addr] ? cells[rd_addr] : ERASED;

endmodule

// File: rtl/eerd_bus_fsm.sv
module eerd_bus_fsm #(
  parameter int          ADDR_W   = 11,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_rise,
  input  logic                        scl_fall,
  input  logic                        sda_lvl,
  input  logic                        start_evt,
  input  logic                        stop_evt,
  input  logic [eerd_pkg::BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0]           cur_addr,
  output logic                        sda_oe,
  output eerd_pkg::state_t            state,
  output logic                        dev_done,
  output logic                        dev_match,
  output logic                        addr_inc,
  output logic                        nack_evt
);
  import eerd_pkg::*;

  localparam int HI_W = ADDR_W - BYTE_W;  // address bits carried by the device byte (1..3)
  localparam logic [3:0] LAST_RX = 4'd7;
  localparam logic [3:0] LAST_TX = 4'd8;

  // Address arithmetic kept in one place.
  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] with_hi(input logic [ADDR_W-1:0] a,
                                                input logic [HI_W-1:0]   hi);
    return {hi, a[BYTE_W-1:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] with_lo(input logic [ADDR_W-1:0] a,
                                                input logic [BYTE_W-1:0] lo);
    return {a[ADDR_W-1:BYTE_W], lo};
  endfunction

  logic [BYTE_W-2:0] sh;       // bits received so far
  logic [BYTE_W-1:0] tx;       // byte being sent, current bit on top
  logic [3:0]        cnt;      // SCL pulses seen in the current byte
  logic              second;   // second half of an acknowledge slot
  logic              rw_rd;    // latched R/W flag
  logic              drv_ack;  // pulling low for an acknowledge
  logic              drv_data; // data byte on the line
  logic [BYTE_W-1:0] rx_byte;

  assign rx_byte   = {sh, sda_lvl};
  assign dev_done  = (state == ST_DEV) && scl_rise && (cnt == LAST_RX);
  assign dev_match = code_hit(rx_byte, DEV_CODE);
  assign addr_inc  = (state == ST_TX) && scl_fall && (cnt == LAST_TX);
  assign nack_evt  = (state == ST_TX_ACK) && scl_rise && sda_lvl;
  // Only zeros are driven; a one is a released line.
  assign sda_oe    = drv_ack | (drv_data & ~tx[BYTE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sh       <= '0;
      tx       <= '0;
      cnt      <= '0;
      second   <= 1'b0;
      rw_rd    <= 1'b0;
      drv_ack  <= 1'b0;
      drv_data <= 1'b0;
      cur_addr <= '0;
    end else if (stop_evt) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      second   <= 1'b0;
      drv_ack  <= 1'b0;
      drv_data <= 1'b0;
    end else if (start_evt) begin
      state    <= ST_DEV;
      cnt      <= '0;
      second   <= 1'b0;
      drv_ack  <= 1'b0;
      drv_data <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;

        ST_DEV: begin
          if (scl_rise) begin
            sh  <= rx_byte[BYTE_W-2:0];
            cnt <= cnt + 1'b1;
            if (cnt == LAST_RX) begin
              cnt <= '0;
              if (dev_match) begin
                rw_rd <= is_read(rx_byte);
                if (!is_read(rx_byte)) cur_addr <= with_hi(cur_addr, rx_byte[HI_W:1]);
                state <= ST_DEV_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
        end

        ST_DEV_ACK: begin
          if (scl_fall) begin
            if (!second) begin
              drv_ack <= 1'b1;
              second  <= 1'b1;
            end else begin
              drv_ack <= 1'b0;
              second  <= 1'b0;
              cnt     <= '0;
              if (rw_rd) begin
                tx       <= rd_data;
                drv_data <= 1'b1;
                state    <= ST_TX;
              end else begin
                state <= ST_WADDR;
              end
            end
          end
        end

        ST_WADDR: begin
          if (scl_rise) begin
            sh  <= rx_byte[BYTE_W-2:0];
            cnt <= cnt + 1'b1;
            if (cnt == LAST_RX) begin
              cnt      <= '0;
              cur_addr <= with_lo(cur_addr, rx_byte);
              state    <= ST_WADDR_ACK;
            end
          end
        end

        ST_WADDR_ACK: begin
          if (scl_fall) begin
            if (!second) begin
              drv_ack <= 1'b1;
              second  <= 1'b1;
            end else begin
              // Data bytes of a write are not taken; wait for start or stop.
              drv_ack <= 1'b0;
              second  <= 1'b0;
              state   <= ST_IDLE;
            end
          end
        end

        ST_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == LAST_TX) begin
              drv_data <= 1'b0;
              cnt      <= '0;
              cur_addr <= step(cur_addr);
              state    <= ST_TX_ACK;
            end else begin
              tx <= {tx[BYTE_W-2:0], 1'b0};
            end
          end
        end

        ST_TX_ACK: begin
          if (scl_rise) begin
            if (sda_lvl) state  <= ST_IDLE;
            else         second <= 1'b1;
          end else if (scl_fall && second) begin
            second   <= 1'b0;
            tx       <= rd_data;
            drv_data <= 1'b1;
            state    <= ST_TX;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_read_target.sv
module eeprom_read_target #(
  parameter int         ADDR_W      = 11,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              load_we,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [7:0]        load_data
);
  import eerd_pkg::*;

  // Named internal events, also watched by the bound checker.
  logic              scl_lvl;
  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_evt;
  logic              stop_evt;
  logic [ADDR_W-1:0] cur_addr;
  logic [BYTE_W-1:0] rd_data;
  state_t            fsm_state;
  logic              dev_done;
  logic              dev_match;
  logic              addr_inc;
  logic              nack_evt;

  eerd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_i),
    .sda_in    (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  eerd_bus_fsm #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rd_data   (rd_data),
    .cur_addr  (cur_addr),
    .sda_oe    (sda_oe),
    .state     (fsm_state),
    .dev_done  (dev_done),
    .dev_match (dev_match),
    .addr_inc  (addr_inc),
    .nack_evt  (nack_evt)
  );

  eerd_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (load_we),
    .wr_addr (load_addr),
    .wr_data (load_data),
    .rd_addr (cur_addr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/eerd_checker.sv
module eerd_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              sda_oe,
  input eerd_pkg::state_t  state,
  input logic              dev_done,
  input logic              dev_match,
  input logic              addr_inc,
  input logic              nack_evt,
  input logic              stop_evt,
  input logic [ADDR_W-1:0] cur_addr
);
  import eerd_pkg::*;

  // R1: an idle engine never holds the line
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R2: a wrong device code sends the engine back to idle
  assert_bad_code_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && !dev_match) |=> (state == ST_IDLE));

  // R5: the pointer moves by exactly one per finished byte
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_inc |=> (cur_addr == $past(cur_addr) + 1'b1));

  // R5: the top address is followed by address zero
  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_inc && (&cur_addr)) |=> (cur_addr == '0));

  // R6: a not-acknowledge ends the read with the line free
  assert_nack_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> (state == ST_IDLE && !sda_oe));

  // R8: a stop always returns to idle
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE));

  // R9: the drive only moves while the bus clock is low
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);

endmodule

bind eeprom_read_target eerd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .sda_oe    (sda_oe),
  .state     (fsm_state),
  .dev_done  (dev_done),
  .dev_match (dev_match),
  .addr_inc  (addr_inc),
  .nack_evt  (nack_evt),
  .stop_evt  (stop_evt),
  .cur_addr  (cur_addr)
);

// File: tb/eeprom_read_target_tb.sv
module eeprom_read_target_tb;

  localparam int H = 20;          // clocks per SCL phase
  localparam int NV = 7;
  // Vector: {kind (0 random, 1 current), start address, byte count}
  localparam logic [16:0] VEC [NV] = '{
    {2'd0, 11'h005, 4'd1},
    {2'd0, 11'h7FE, 4'd4},
    {2'd1, 11'h000, 4'd2},
    {2'd0, 11'h400, 4'd2},
    {2'd0, 11'h03C, 4'd3},
    {2'd1, 11'h000, 4'd1},
    {2'd0, 11'h7FC, 4'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl;
  logic        m_sda;
  logic        sda_oe;
  logic        load_we;
  logic [10:0] load_addr;
  logic [7:0]  load_data;
  wire         sda_line = m_sda & ~sda_oe;

  int   n_chk = 0;
  int   n_bad = 0;
  int   r9_bad = 0;
  bit   done = 1'b0;
  logic [7:0]  model [2048];
  logic [10:0] ptr;

  always #4 clk = ~clk;

  eeprom_read_target u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .load_we   (load_we),
    .load_addr (load_addr),
    .load_data (load_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [10:0] a);
    return 8'((a * 11'd29) ^ 11'h05A);
  endfunction

  task automatic load(input logic [10:0] a, input logic [7:0] d);
    load_we = 1'b1; load_addr = a; load_data = d;
    tick(1);
    load_we = 1'b0;
    model[a] = d;
  endtask

  // One SCL pulse, entered and left with SCL low; SDA read mid-high.
  task automatic clk_bit(input logic b, output logic seen);
    logic oe_mid;
    m_sda = b; tick(H/2);
    scl = 1'b1; tick(H/2);
    seen = sda_line; oe_mid = sda_oe;
    tick(H/2 - 1);
    if (sda_oe !== oe_mid) r9_bad++;
    tick(1);
    scl = 1'b0; tick(H/2);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(H/2);
    scl = 1'b1;   tick(H/2);
    m_sda = 1'b0; tick(H/2);
    scl = 1'b0;   tick(H/2);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(H/2);
    scl = 1'b1;   tick(H/2);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic do_random(input logic [10:0] a);
    logic ak;
    bus_start;
    send_byte({4'b1010, a[10:8], 1'b0}, ak);
    chk("R2", "write device byte ack", int'(ak), 1);
    send_byte(a[7:0], ak);
    chk("R3", "word address ack", int'(ak), 1);
    ptr = a;
    bus_start;
    send_byte({4'b1010, a[10:8], 1'b1}, ak);
    chk("R3", "read device byte ack", int'(ak), 1);
  endtask

  task automatic do_current;
    logic ak;
    bus_start;
    send_byte({4'b1010, 3'b000, 1'b1}, ak);
    chk("R7", "current read device ack", int'(ak), 1);
  endtask

  task automatic read_run(input int len, input string req);
    logic [7:0] d;
    for (int k = 0; k < len; k++) begin
      recv_byte(k != len - 1, d);
      chk(req, "data msb-first R4", int'(d), int'(model[ptr]));
      ptr = ptr + 11'd1;
    end
    chk("R6", "line released after nack", int'(sda_oe), 0);
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic s;
    for (int a = 0; a < 2048; a++) model[a] = 8'hFF;
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1;
    load_we = 1'b0; load_addr = '0; load_data = '0;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk("R1", "sda_oe after reset", int'(sda_oe), 0);

    // R10: fill known contents through the load port
    for (int a = 0; a < 64; a++) load(11'(a), pat(11'(a)));
    for (int a = 2040; a < 2048; a++) load(11'(a), pat(11'(a)));
    load(11'h501, 8'h00);
    ptr = '0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16:15] == 2'd0) do_random(VEC[i][14:4]);
      else                       do_current;
      if (VEC[i][16:15] == 2'd1)      read_run(int'(VEC[i][3:0]), "R7");
      else if (VEC[i][3:0] > 4'd1)    read_run(int'(VEC[i][3:0]), "R5");
      else                            read_run(int'(VEC[i][3:0]), "R10");
    end

    // R1: never-loaded region reads erased (also covered at 0x400 above)
    do_random(11'h6A3);
    read_run(1, "R1");

    // R2: foreign device code is not acknowledged and changes nothing
    bus_start;
    send_byte({4'b1011, 3'b000, 1'b0}, ak);
    chk("R2", "foreign code ack", int'(ak), 0);
    send_byte(8'h10, ak);
    chk("R2", "byte after foreign code ack", int'(ak), 0);
    bus_stop;
    do_current;
    read_run(1, "R2");

    // R11: data byte after the word address is refused and not stored
    bus_start;
    send_byte({4'b1010, 3'b000, 1'b0}, ak);
    chk("R2", "write device ack", int'(ak), 1);
    send_byte(8'h10, ak);
    chk("R3", "word ack", int'(ak), 1);
    send_byte(8'h55, ak);
    chk("R11", "write data ack", int'(ak), 0);
    bus_stop;
    ptr = 11'h010;
    do_current;
    read_run(1, "R11");

    // R8: stop inside the word address byte
    bus_start;
    send_byte({4'b1010, 3'b101, 1'b0}, ak);
    chk("R2", "device ack before abort", int'(ak), 1);
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
    bus_stop;
    chk("R8", "released after stop in word byte", int'(sda_oe), 0);
    ptr = {3'b101, ptr[7:0]};
    do_current;
    read_run(1, "R8");

    // R8: stop inside a data byte leaves the pointer where it was
    do_random(11'h500);
    clk_bit(1'b1, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
    bus_stop;
    chk("R8", "released after stop in data byte", int'(sda_oe), 0);
    ptr = 11'h500;
    do_current;
    read_run(2, "R8");

    chk("R9", "sda_oe moves during SCL high", r9_bad, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule